// File: doc/BRIEF.md
# Oversampled UART Receiver Channel

This block is one asynchronous serial receive channel. The serial line idles high. The block looks for a falling edge on that line and confirms the start bit with a clock enable that pulses sixteen times per bit period. After that it takes one sample of each following bit near the middle of the bit. The data bits go into a shift register. The block then checks parity when parity is enabled, and checks the stop bit. The finished character moves into a single holding register, where the host reads it through a simple read strobe.

The character length is selectable from five to eight bits. Parity can be off, even or odd. Three error flags go into the holding register with the character: parity error, framing error and overrun. The serial input first passes through a two-flop synchronizer. All state is clocked on one clock and advances only on cycles where the 16x enable is high. The block re-establishes its bit-centre timing on every start bit, so characters may arrive back to back.

Top module: `uart_rx_channel`

## Requirements
- R1: After reset, `data_ready`, `parity_err`, `framing_err` and `overrun` are 0 and `rd_data` is all zeros.
- R2: A low level seen on the synchronized line at a 16x enable after a high one opens a start window. If the line is high again at the seventh enable sample, the low pulse is discarded and no character is produced. A low pulse lasting five or fewer enable periods therefore never sets `data_ready`.
- R3: Data bits arrive least significant bit first and are sampled every 16 enables after the qualifying start sample. `cfg_char_len` selects the length: 0=5 bits, 1=6, 2=7, 3=8. `rd_data` is right-justified and its unused upper bits read 0.
- R4: When `cfg_parity_en`=1, one parity bit follows the data. With `cfg_parity_odd`=0 the expected bit is the XOR of the data bits (even). With `cfg_parity_odd`=1 it is the inverse of that XOR (odd). A mismatch sets `parity_err` for that character. With parity disabled, `parity_err` is 0.
- R5: A low level at the stop-bit sample sets `framing_err` for that character. The character is still delivered.
- R6: A completed character sets `data_ready`. A one-cycle `rd_strobe` clears `data_ready`. `rd_data` and its flags stay unchanged until the next character is loaded.
- R7: A character that completes while `data_ready` is set, with no read strobe in that cycle, is discarded and sets `overrun`. `rd_strobe` clears `overrun`.
- R8: Characters sent back to back, with a single stop bit between them, are each received correctly, because the sample phase is re-established on every start bit.
- R9: The receive state machine leaves idle only on a cycle with the 16x enable active while the synchronized line is low. It completes a character only on a cycle that follows an active enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Clock enable at sixteen times the baud rate |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| cfg_char_len | input | 2 | Character length select (0..3 → 5..8 bits) |
| cfg_parity_en | input | 1 | Parity bit present and checked |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Host read of the holding register |
| rd_data | output | 8 | Received character, right-justified |
| data_ready | output | 1 | Holding register contains an unread character |
| parity_err | output | 1 | Parity mismatch on the held character |
| framing_err | output | 1 | Stop bit sampled low on the held character |
| overrun | output | 1 | A character was lost because the holding register was full |

## Verification
The assertions run on every cycle. They check that `data_ready` and `overrun` change only for the reasons allowed, that the held character stays put while it is unread, and that the state machine starts and finishes only on enable cycles. Correct bit ordering, the length and parity encodings, the rejection of noise pulses and the realignment between back-to-back characters depend on complete serial waveforms. Only the bench scenarios can show those. The bench sweeps every length and parity combination, sends every 5-bit value, and injects parity errors, framing errors, overruns and short glitches.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the receive channel.
// Assumes nothing beyond standard SystemVerilog.
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE   = 3'd0,
        RX_START  = 3'd1,
        RX_DATA   = 3'd2,
        RX_PARITY = 3'd3,
        RX_STOP   = 3'd4
    } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
// Module: multi-stage synchronizer for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to 1.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] pipe_q;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], async_i};
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
// Module: start qualification, bit timing, shift register, parity and stop check.
// Assumes a synchronized input and a one-cycle enable at OVS times the baud rate.
// Emits a one-cycle done pulse with the character and its error flags.
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OVS     = 16,
    parameter int QUAL    = 7,
    parameter int MIN_LEN = 5,
    parameter int SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_i,
    input  logic [SEL_W-1:0]  len_sel,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] char_o,
    output logic              perr_o,
    output logic              ferr_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);

    rx_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_acc_q;
    logic              par_bit_q;
    logic              prev_line_q;

    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W:0]    shamt;
    logic              bit_mid;
    logic              qual_hit;
    logic              exp_par;

    // Derive the length-dependent limits and the sample strobes.
    always_comb begin
        last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(len_sel);
        shamt    = (IDX_W+1)'(DATA_W - MIN_LEN) - (IDX_W+1)'(len_sel);
        bit_mid  = (cnt_q == CNT_W'(OVS - 1));
        qual_hit = (cnt_q == CNT_W'(QUAL - 2));
        exp_par  = par_acc_q ^ par_odd;
    end

    // Receive state machine, advanced only on enable cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RX_IDLE;
            cnt_q       <= '0;
            idx_q       <= '0;
            shift_q     <= '0;
            par_acc_q   <= 1'b0;
            par_bit_q   <= 1'b0;
            prev_line_q <= 1'b1;
            done_o      <= 1'b0;
            char_o      <= '0;
            perr_o      <= 1'b0;
            ferr_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick) begin
                prev_line_q <= line_i;
                case (state_q)
                    RX_IDLE: begin
                        if (prev_line_q && !line_i) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (qual_hit) begin
                            if (!line_i) begin
                                state_q   <= RX_DATA;
                                cnt_q     <= '0;
                                idx_q     <= '0;
                                par_acc_q <= 1'b0;
                            end else begin
                                state_q <= RX_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (bit_mid) begin
                            cnt_q     <= '0;
                            shift_q   <= {line_i, shift_q[DATA_W-1:1]};
                            par_acc_q <= par_acc_q ^ line_i;
                            idx_q     <= idx_q + 1'b1;
                            if (idx_q == last_idx)
                                state_q <= par_en ? RX_PARITY : RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (bit_mid) begin
                            cnt_q     <= '0;
                            par_bit_q <= line_i;
                            state_q   <= RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (bit_mid) begin
                            cnt_q   <= '0;
                            done_o  <= 1'b1;
                            char_o  <= shift_q >> shamt;
                            ferr_o  <= !line_i;
                            perr_o  <= par_en && (par_bit_q != exp_par);
                            state_q <= RX_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign busy_o = (state_q != RX_IDLE);
endmodule

// File: rtl/uart_rx_holding.sv
// Module: one-character holding register with ready and overrun flags.
// Assumes done is a one-cycle pulse and the read strobe is a one-cycle pulse.
module uart_rx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] char_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              perr_o,
    output logic              ferr_o,
    output logic              ovr_o
);
    // Load a new character, or flag overrun, and service host reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            ready_o <= 1'b0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
            ovr_o   <= 1'b0;
        end else begin
            if (rd_i) begin
                ready_o <= 1'b0;
                ovr_o   <= 1'b0;
            end
            if (done_i) begin
                if (ready_o && !rd_i) begin
                    ovr_o <= 1'b1;
                end else begin
                    data_o  <= char_i;
                    perr_o  <= perr_i;
                    ferr_o  <= ferr_i;
                    ready_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_channel.sv
// Module: top of the receive channel; synchronizer, framer and holding register.
// Assumes tick16 is a single-cycle enable at 16x the baud rate in the clk domain.
module uart_rx_channel #(
    parameter int DATA_W    = 8,
    parameter int OVS       = 16,
    parameter int QUAL      = 7,
    parameter int MIN_LEN   = 5,
    parameter int SEL_W     = 2,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_serial,
    input  logic [SEL_W-1:0]  cfg_char_len,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_ready,
    output logic              parity_err,
    output logic              framing_err,
    output logic              overrun
);
    logic              rx_sync;
    logic              rx_busy;
    logic              rx_done;
    logic [DATA_W-1:0] rx_char;
    logic              rx_perr;
    logic              rx_ferr;

    uart_rx_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rx_serial),
        .sync_o  (rx_sync)
    );

    uart_rx_framer #(
        .DATA_W  (DATA_W),
        .OVS     (OVS),
        .QUAL    (QUAL),
        .MIN_LEN (MIN_LEN),
        .SEL_W   (SEL_W)
    ) framer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .line_i  (rx_sync),
        .len_sel (cfg_char_len),
        .par_en  (cfg_parity_en),
        .par_odd (cfg_parity_odd),
        .busy_o  (rx_busy),
        .done_o  (rx_done),
        .char_o  (rx_char),
        .perr_o  (rx_perr),
        .ferr_o  (rx_ferr)
    );

    uart_rx_holding #(.DATA_W(DATA_W)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (rx_done),
        .char_i  (rx_char),
        .perr_i  (rx_perr),
        .ferr_i  (rx_ferr),
        .rd_i    (rd_strobe),
        .data_o  (rd_data),
        .ready_o (data_ready),
        .perr_o  (parity_err),
        .ferr_o  (framing_err),
        .ovr_o   (overrun)
    );
endmodule

// File: rtl/uart_rx_channel_chk.sv
// Module: protocol checker bound to the receive channel top.
// Assumes synchronous active-low reset held for at least one clock.
module uart_rx_channel_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick16,
    input logic              rx_sync,
    input logic              rx_busy,
    input logic              rx_done,
    input logic              rd_strobe,
    input logic              data_ready,
    input logic              overrun,
    input logic [DATA_W-1:0] rd_data
);
    // R6: ready drops only after a host read.
    assert_ready_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> $past(rd_strobe));

    // R6: the held character is frozen while it is unread.
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(data_ready) && !$past(rd_strobe)) |-> $stable(rd_data));

    // R7: overrun appears only when a character was already waiting.
    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(data_ready));

    // R9: the state machine leaves idle only on an enable with the line low.
    assert_start_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_busy) |-> ($past(tick16) && !$past(rx_sync)));

    // R9: a character completes only after an enable cycle.
    assert_done_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(tick16));
endmodule

bind uart_rx_channel uart_rx_channel_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .rx_sync    (rx_sync),
    .rx_busy    (rx_busy),
    .rx_done    (rx_done),
    .rd_strobe  (rd_strobe),
    .data_ready (data_ready),
    .overrun    (overrun),
    .rd_data    (rd_data)
);

// File: tb/uart_rx_channel_tb_top.sv
// Bench: sweeps lengths, parity modes and data values; checks errors and noise.
module uart_rx_channel_tb_top;
    localparam int BIT_CLK  = 32;       // 16 enables, one every 2 clocks
    localparam int WD_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_serial = 1'b1;
    logic [1:0] cfg_char_len = 2'd3;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       data_ready, parity_err, framing_err, overrun;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_rx_channel dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick16         (tick16),
        .rx_serial      (rx_serial),
        .cfg_char_len   (cfg_char_len),
        .cfg_parity_en  (cfg_parity_en),
        .cfg_parity_odd (cfg_parity_odd),
        .rd_strobe      (rd_strobe),
        .rd_data        (rd_data),
        .data_ready     (data_ready),
        .parity_err     (parity_err),
        .framing_err    (framing_err),
        .overrun        (overrun)
    );

    // 16x enable: every second clock.
    always @(negedge clk) begin
        if (!rst_n) tick16 <= 1'b0;
        else        tick16 <= ~tick16;
    end

    // Watchdog: a hung run is a failure that still reports.
    always @(negedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] len_mask(input int len);
        return 8'((9'd1 << len) - 9'd1);
    endfunction

    // par: 0 none, 1 even, 2 odd
    task automatic send_char(input logic [7:0] d, input int len, input int par,
                             input bit bad_par, input bit stop_val);
        logic p;
        rx_serial = 1'b0;
        wait_clk(BIT_CLK);
        for (int i = 0; i < len; i++) begin
            rx_serial = d[i];
            wait_clk(BIT_CLK);
        end
        if (par != 0) begin
            p = ^(d & len_mask(len));
            if (par == 2) p = ~p;
            if (bad_par)  p = ~p;
            rx_serial = p;
            wait_clk(BIT_CLK);
        end
        rx_serial = stop_val;
        wait_clk(BIT_CLK);
        rx_serial = 1'b1;
    endtask

    task automatic read_pulse();
        rd_strobe = 1'b1;
        wait_clk(1);
        rd_strobe = 1'b0;
        wait_clk(1);
    endtask

    task automatic expect_char(input logic [7:0] d, input bit pe, input bit fe,
                               input bit ov, input bit do_read);
        chk("R6 data_ready set", {31'd0, data_ready}, 32'd1);
        chk("R3 rd_data", {24'd0, rd_data}, {24'd0, d});
        chk("R4 parity_err", {31'd0, parity_err}, {31'd0, pe});
        chk("R5 framing_err", {31'd0, framing_err}, {31'd0, fe});
        chk("R7 overrun", {31'd0, overrun}, {31'd0, ov});
        if (do_read) begin
            read_pulse();
            chk("R6 data_ready cleared", {31'd0, data_ready}, 32'd0);
            chk("R7 overrun cleared", {31'd0, overrun}, 32'd0);
        end
    endtask

    task automatic set_cfg(input int len, input int par);
        cfg_char_len   = 2'(len - 5);
        cfg_parity_en  = (par != 0);
        cfg_parity_odd = (par == 2);
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] first;
        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: reset state
        chk("R1 data_ready", {31'd0, data_ready}, 32'd0);
        chk("R1 parity_err", {31'd0, parity_err}, 32'd0);
        chk("R1 framing_err", {31'd0, framing_err}, 32'd0);
        chk("R1 overrun", {31'd0, overrun}, 32'd0);
        chk("R1 rd_data", {24'd0, rd_data}, 32'd0);
        wait_clk(2 * BIT_CLK);

        // R3 R4 R8: every length and parity mode, back to back
        for (int len = 5; len <= 8; len++) begin
            for (int par = 0; par < 3; par++) begin
                set_cfg(len, par);
                for (int v = 0; v < 16; v++) begin
                    d = 8'((v * 37 + len * 11 + par * 5) & 255);
                    if (v == 0)  d = 8'h00;
                    if (v == 15) d = 8'hFF;
                    send_char(d, len, par, 1'b0, 1'b1);
                    expect_char(d & len_mask(len), 1'b0, 1'b0, 1'b0, 1'b1);
                end
            end
        end

        // R3: every 5-bit value, upper bits must read zero
        set_cfg(5, 0);
        for (int v = 0; v < 32; v++) begin
            send_char(8'(v) | 8'hE0, 5, 0, 1'b0, 1'b1);
            expect_char(8'(v), 1'b0, 1'b0, 1'b0, 1'b1);
        end

        // R4: injected parity errors
        for (int len = 5; len <= 8; len++) begin
            for (int par = 1; par < 3; par++) begin
                set_cfg(len, par);
                d = 8'(8'h5A + len + par);
                send_char(d, len, par, 1'b1, 1'b1);
                expect_char(d & len_mask(len), 1'b1, 1'b0, 1'b0, 1'b1);
            end
        end

        // R5: framing error, character still delivered
        set_cfg(8, 0);
        send_char(8'hC3, 8, 0, 1'b0, 1'b0);
        wait_clk(BIT_CLK);
        expect_char(8'hC3, 1'b0, 1'b1, 1'b0, 1'b1);
        set_cfg(7, 1);
        send_char(8'h2D, 7, 1, 1'b1, 1'b0);
        wait_clk(BIT_CLK);
        expect_char(8'h2D, 1'b1, 1'b1, 1'b0, 1'b1);

        // R2: short low glitch is discarded, then R8: next character aligns
        set_cfg(8, 0);
        rx_serial = 1'b0;
        wait_clk(10);
        rx_serial = 1'b1;
        wait_clk(3 * BIT_CLK);
        chk("R2 glitch ignored", {31'd0, data_ready}, 32'd0);
        send_char(8'hA5, 8, 0, 1'b0, 1'b1);
        expect_char(8'hA5, 1'b0, 1'b0, 1'b0, 1'b1);

        // R7: second character while unread is lost
        first = 8'h3C;
        send_char(first, 8, 0, 1'b0, 1'b1);
        expect_char(first, 1'b0, 1'b0, 1'b0, 1'b0);
        send_char(8'hE1, 8, 0, 1'b0, 1'b1);
        expect_char(first, 1'b0, 1'b0, 1'b1, 1'b1);
        // R7: after the read, a new character arrives cleanly
        send_char(8'h81, 8, 0, 1'b0, 1'b1);
        expect_char(8'h81, 1'b0, 1'b0, 1'b0, 1'b1);

        wait_clk(4);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule